// File: doc/BRIEF.md
# Retirement Watchdog Timer

This block watches for a stalled instruction pipeline. It counts time in which no instruction retires and no exception is taken. The count runs in units of the bus clock, which is slower than the core clock. The block runs in the core clock domain, and a bus-clock enable marks each bus tick. A first-stage prescaler turns every `PRESCALE_DIV` bus ticks into one step of a `MAIN_W`-bit main counter. When a step arrives while the main counter is all ones, a 1 carries out of its top bit and a timeout fires. With the default values, a timeout needs 128 × 32768 uninterrupted bus ticks.

A retire pulse or an exception pulse sets both counters back to zero, so every clear restarts the whole interval. The timeout itself also restarts the interval. A timeout drives a one-cycle event output and sets a sticky status bit. Later timeouts and counter clears do not change that bit. Only reset or an explicit status-clear input brings it back to zero.

A two-state controller produces the event. It rests in `ST_WATCH`. It takes the transition *fire* to `ST_ALARM` when the main counter carries out and no retire or exception arrives in that cycle. From `ST_ALARM` it takes the transition *rearm* back to `ST_WATCH` on the next cycle. The event output is high only while the controller is in `ST_ALARM`.

Top module: `rwd_watchdog`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, `timeout_evt_o` and `timeout_sts_o` are 0, both counters are zero, and the controller is in `ST_WATCH`.
- R2: Only core cycles with `bus_tick_en_i` = 1 advance the prescaler. The main counter advances only on a prescaler carry. Core cycles with `bus_tick_en_i` = 0 change nothing, in any number.
- R3: The prescaler carries on every `PRESCALE_DIV`-th tick. A timeout therefore needs exactly `PRESCALE_DIV` × 2^`MAIN_W` ticks with no clear between them.
- R4: The tick that causes the carry out of the main counter's top bit is sampled on a clock edge. `timeout_evt_o` is 1 in the cycle after that edge, for exactly one cycle.
- R5: A cycle with `retire_i` = 1 clears the prescaler and the main counter. A new timeout then needs a full interval of ticks that follow the clear.
- R6: A cycle with `exception_i` = 1 clears both counters in the same way as a retire.
- R7: A retire or exception in the same cycle as the carry takes priority. No event is raised, the status bit is not set, and the counters restart from zero.
- R8: After a timeout, both counters restart from zero. Without any clear, the next event follows after one more full interval.
- R9: A timeout sets `timeout_sts_o` to 1 in the same cycle as the event. The bit then stays 1 through later events, retires and exceptions. It clears only on reset or in the cycle after `status_clr_i` = 1. If a timeout and `status_clr_i` arrive in the same cycle, the timeout wins and the bit stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_tick_en_i | input | 1 | One bus-clock tick in this core cycle |
| retire_i | input | 1 | An instruction retired this cycle |
| exception_i | input | 1 | The core detected an exception this cycle |
| status_clr_i | input | 1 | Clears the sticky timeout status bit |
| timeout_evt_o | output | 1 | One-cycle timeout event pulse |
| timeout_sts_o | output | 1 | Sticky timeout status |

## Verification
The counters and the controller cannot be seen directly. A wrong internal count shows only as an event that comes too early, too late, or not at all. The bench therefore runs exactly one tick short of the interval and exactly on it, spreads the ticks with gaps of idle cycles, and places a clear on the very tick of the carry. A prescaler or main counter that fails to clear shows one interval later, as an early event after a retire, an exception or a previous timeout. A wrong status bit shows in the cycle right after the event or right after a clear request.

// File: rtl/rwd_pkg.sv
package rwd_pkg;

    // Controller states of the retirement watchdog
    typedef enum logic {
        ST_WATCH = 1'b0,   // counting, no event
        ST_ALARM = 1'b1    // one-cycle timeout event
    } rwd_state_e;

endpackage

// File: rtl/rwd_prescaler.sv
// First stage: divides bus ticks by DIV, with a synchronous clear
module rwd_prescaler #(
    parameter int unsigned DIV = 128
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic clr_i,
    output logic carry_o
);
    localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);
    localparam bit POW2 = ((DIV & (DIV - 1)) == 0);

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] cnt_d;
    logic          at_last;

    generate
        if (POW2) begin : g_pow2
            // The counter wraps by itself and the carry is all-ones
            assign at_last = &cnt_q;
        end else begin : g_cmp
            assign at_last = (cnt_q == LAST);
        end
    endgenerate

    assign carry_o = tick_i && at_last;

    always_comb begin
        cnt_d = cnt_q;
        if (clr_i) begin
            cnt_d = '0;
        end else if (tick_i) begin
            cnt_d = at_last ? '0 : cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // R2: with no tick and no clear, the prescaler holds
    p_pre_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_i && !clr_i) |=> $stable(cnt_q));

    // R3: the count stays below the divide ratio
    p_pre_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST);

    // R3: a carry returns the prescaler to zero
    p_pre_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        carry_o |=> (cnt_q == '0));

    // R5: a clear empties the prescaler
    p_pre_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (cnt_q == '0));

endmodule

// File: rtl/rwd_main_counter.sv
// Second stage: a W-bit counter; a carry out of its top bit is a timeout
module rwd_main_counter #(
    parameter int unsigned W = 15
) (
    input  logic clk,
    input  logic rst_n,
    input  logic inc_i,
    input  logic clr_i,
    output logic carry_o
);
    logic [W-1:0] cnt_q;
    logic [W:0]   sum;

    // The extra bit of the sum is the carry out of the top bit
    assign sum     = {1'b0, cnt_q} + {{W{1'b0}}, 1'b1};
    assign carry_o = inc_i && sum[W];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr_i) begin
            cnt_q <= '0;
        end else if (inc_i) begin
            cnt_q <= sum[W-1:0];
        end
    end

    // R2: without a prescaler carry the main count does not move
    p_main_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!inc_i && !clr_i) |=> $stable(cnt_q));

    // R8: after a carry out the main counter starts again from zero
    p_main_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
        carry_o |=> (cnt_q == '0));

    // R6: a clear empties the main counter
    p_main_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (cnt_q == '0));

endmodule

// File: rtl/rwd_sticky.sv
// Sticky status bit: a set wins over a clear in the same cycle
module rwd_sticky (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic q_o
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q_o <= 1'b0;
        end else if (set_i) begin
            q_o <= 1'b1;
        end else if (clr_i) begin
            q_o <= 1'b0;
        end
    end

    // R9: a set is never lost, even with a clear request
    p_sts_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> q_o);

    // R9: the bit stays up until asked to drop
    p_sts_keep_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (q_o && !clr_i) |=> q_o);

endmodule

// File: rtl/rwd_watchdog.sv
// Retirement watchdog: prescaler, main counter, event controller, status
module rwd_watchdog #(
    parameter int unsigned PRESCALE_DIV = 128,
    parameter int unsigned MAIN_W       = 15
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bus_tick_en_i,
    input  logic retire_i,
    input  logic exception_i,
    input  logic status_clr_i,
    output logic timeout_evt_o,
    output logic timeout_sts_o
);
    import rwd_pkg::*;

    rwd_state_e state_q;
    rwd_state_e state_d;

    logic ext_clr;     // retire or exception this cycle
    logic pre_carry;   // prescaler step into the main counter
    logic main_carry;  // carry out of the main counter's top bit
    logic fire;        // a timeout is taken this cycle
    logic cnt_clr;     // clear for both counters

    // A retire or exception overrides a carry in the same cycle
    assign ext_clr = retire_i || exception_i;
    assign fire    = main_carry && !ext_clr;
    assign cnt_clr = ext_clr || fire;

    rwd_prescaler #(
        .DIV (PRESCALE_DIV)
    ) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_i  (bus_tick_en_i),
        .clr_i   (cnt_clr),
        .carry_o (pre_carry)
    );

    rwd_main_counter #(
        .W (MAIN_W)
    ) u_main (
        .clk     (clk),
        .rst_n   (rst_n),
        .inc_i   (pre_carry),
        .clr_i   (cnt_clr),
        .carry_o (main_carry)
    );

    rwd_sticky u_sts (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (fire),
        .clr_i (status_clr_i),
        .q_o   (timeout_sts_o)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_WATCH: if (fire) state_d = ST_ALARM;              // fire
            ST_ALARM: state_d = fire ? ST_ALARM : ST_WATCH;      // rearm
            default:  state_d = ST_WATCH;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_WATCH;
        else        state_q <= state_d;
    end

    // Outputs
    always_comb begin
        unique case (state_q)
            ST_ALARM: timeout_evt_o = 1'b1;
            default:  timeout_evt_o = 1'b0;
        endcase
    end

    // R4: the event is a single-cycle pulse
    p_evt_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_evt_o |=> !timeout_evt_o);

    // R7: a retire or exception in any cycle suppresses an event after it
    p_clear_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (retire_i || exception_i) |=> !timeout_evt_o);

    // R9: the status bit is up whenever the event is
    p_evt_sts_r9: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_evt_o |-> timeout_sts_o);

    // R9: the status bit does not drop without a clear request
    p_sts_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (timeout_sts_o && !status_clr_i) |=> timeout_sts_o);

    // R1: reset leaves no event pending
    p_reset_quiet_r1: assert property (@(posedge clk)
        $rose(rst_n) |-> !timeout_evt_o);

endmodule

// File: tb/rwd_watchdog_tb.sv
module rwd_watchdog_tb;

    localparam int unsigned DIV      = 4;
    localparam int unsigned MW       = 3;
    localparam int unsigned INTERVAL = DIV * (1 << MW);   // 32 ticks
    localparam int unsigned WD_LIMIT = 100000;

    // kind: 0 = no clear, 1 = retire on last tick, 2 = exception on last tick
    typedef struct packed {
        int unsigned ticks;
        int unsigned period;
        int unsigned kind;
        int unsigned expect_evt;
    } vec_t;

    localparam int NVEC = 8;
    localparam vec_t VECS [NVEC] = '{
        '{INTERVAL,      1, 0, 1},   // R3 R4 full interval
        '{INTERVAL - 1,  1, 0, 0},   // R3 one tick short
        '{INTERVAL,      3, 0, 1},   // R2 idle gaps do not count
        '{INTERVAL,      1, 1, 0},   // R7 retire on carry tick
        '{INTERVAL,      2, 2, 0},   // R7 exception on carry tick
        '{INTERVAL - 12, 1, 1, 0},   // R5 early retire
        '{INTERVAL,      4, 0, 1},   // R2 sparse ticks
        '{INTERVAL / 2,  2, 0, 0}    // R3 half interval
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick = 1'b0;
    logic ret = 1'b0;
    logic exc = 1'b0;
    logic sclr = 1'b0;
    logic evt;
    logic sts;

    int checks = 0;
    int errors = 0;
    int evt_seen = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    rwd_watchdog #(
        .PRESCALE_DIV (DIV),
        .MAIN_W       (MW)
    ) u_dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .bus_tick_en_i (tick),
        .retire_i      (ret),
        .exception_i   (exc),
        .status_clr_i  (sclr),
        .timeout_evt_o (evt),
        .timeout_sts_o (sts)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // One core cycle: drive at negedge, sample 1 ns after posedge
    task automatic cyc(input logic t, input logic r, input logic e, input logic c);
        @(negedge clk);
        tick = t; ret = r; exc = e; sclr = c;
        @(posedge clk);
        #1;
        if (evt) evt_seen++;
    endtask

    task automatic run_ticks(input int unsigned n, input int unsigned period,
                             input int unsigned kind, input logic clr_last);
        for (int unsigned i = 0; i < n; i++) begin
            for (int unsigned p = 1; p < period; p++) cyc(1'b0, 1'b0, 1'b0, 1'b0);
            cyc(1'b1, (i == n - 1) && (kind == 1), (i == n - 1) && (kind == 2),
                (i == n - 1) && clr_last);
        end
    endtask

    task automatic idle(input int unsigned n);
        for (int unsigned i = 0; i < n; i++) cyc(1'b0, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; tick = 1'b0; ret = 1'b0; exc = 1'b0; sclr = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        chk(evt == 1'b0, "R1 event low in reset", evt, 0);
        chk(sts == 1'b0, "R1 status low in reset", sts, 0);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin : watchdog
        int n = 0;
        while (!done && n < WD_LIMIT) begin
            @(posedge clk);
            n++;
        end
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", n, 0);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        do_reset();
        idle(1);
        chk(evt == 1'b0, "R1 event low after reset", evt, 0);
        chk(sts == 1'b0, "R1 status low after reset", sts, 0);

        // Vector table
        for (int v = 0; v < NVEC; v++) begin
            cyc(1'b0, 1'b1, 1'b0, 1'b0);        // fresh start via retire
            evt_seen = 0;
            run_ticks(VECS[v].ticks, VECS[v].period, VECS[v].kind, 1'b0);
            idle(2);
            chk(evt_seen == int'(VECS[v].expect_evt),
                $sformatf("R3/R4/R7 vector %0d event count", v),
                evt_seen, int'(VECS[v].expect_evt));
        end

        // R2: many idle cycles never fire
        do_reset();
        evt_seen = 0;
        run_ticks(INTERVAL - 1, 1, 0, 1'b0);
        idle(500);
        chk(evt_seen == 0, "R2 idle cycles do not count", evt_seen, 0);
        run_ticks(1, 1, 0, 1'b0);
        chk(evt == 1'b1, "R2 last tick after idle fires", evt, 1);
        chk(sts == 1'b1, "R9 status set with event", sts, 1);
        idle(1);
        chk(evt == 1'b0, "R4 event lasts one cycle", evt, 0);

        // R5: retire mid-interval restarts the full interval
        do_reset();
        evt_seen = 0;
        run_ticks(20, 1, 1, 1'b0);
        run_ticks(INTERVAL - 1, 1, 0, 1'b0);
        chk(evt_seen == 0, "R5 no event before full interval after retire", evt_seen, 0);
        run_ticks(1, 1, 0, 1'b0);
        chk(evt == 1'b1, "R5 event after full interval", evt, 1);

        // R6: exception restarts the interval too
        do_reset();
        evt_seen = 0;
        run_ticks(25, 2, 2, 1'b0);
        run_ticks(INTERVAL - 1, 1, 0, 1'b0);
        chk(evt_seen == 0, "R6 no event before full interval after exception", evt_seen, 0);
        run_ticks(1, 1, 0, 1'b0);
        chk(evt == 1'b1, "R6 event after full interval", evt, 1);

        // R8: a second interval follows the first event
        evt_seen = 0;
        run_ticks(INTERVAL - 1, 1, 0, 1'b0);
        chk(evt_seen == 0, "R8 no early second event", evt_seen, 0);
        run_ticks(1, 1, 0, 1'b0);
        chk(evt == 1'b1, "R8 second event after one interval", evt, 1);

        // R9: sticky through clears, dropped only by status clear
        cyc(1'b0, 1'b1, 1'b0, 1'b0);
        cyc(1'b0, 1'b0, 1'b1, 1'b0);
        chk(sts == 1'b1, "R9 status survives retire and exception", sts, 1);
        cyc(1'b0, 1'b0, 1'b0, 1'b1);
        chk(sts == 1'b0, "R9 status clear request", sts, 0);
        run_ticks(INTERVAL - 1, 1, 0, 1'b0);
        run_ticks(1, 1, 0, 1'b1);                // event and clear together
        chk(evt == 1'b1, "R9 event with simultaneous clear", evt, 1);
        chk(sts == 1'b1, "R9 set beats simultaneous clear", sts, 1);

        // R7: clear on carry tick leaves status low
        cyc(1'b0, 1'b0, 1'b0, 1'b1);
        run_ticks(INTERVAL, 1, 1, 1'b0);
        chk(sts == 1'b0, "R7 no status after suppressed carry", sts, 0);

        // R1: reset drops a set status
        run_ticks(INTERVAL, 1, 0, 1'b0);
        chk(sts == 1'b1, "R9 status set again", sts, 1);
        do_reset();
        idle(1);
        chk(sts == 1'b0, "R1 reset clears status", sts, 0);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule